// File: doc/BRIEF.md
# Latched 4-to-16 One-Hot Address Decoder

This block holds a binary address in a level-sensitive storage element and turns the held value into a sixteen-wide active-high one-hot vector. A load-enable input chooses the mode. While load-enable is high the store is transparent, so the outputs track the address bus. While it is low the store keeps the value that was present when it fell. An active-high chip-select input blanks every output. It does not touch the stored address.

Chip-select can also serve as an inverted data line. Software sets the address to pick one output. The chosen output then carries the complement of chip-select, so the block works as a 1-to-16 demultiplexer, and several blocks can be cascaded through their selects. A parameter swaps the level-sensitive store for a clocked register for targets that avoid latches. An asynchronous active-low reset, released synchronously, clears the stored address to zero.

Top module: `latched_addr_decoder`

## Requirements
- R1: While load_en_i is high (and reset is released), the stored code equals addr_i, and sel_o decodes addr_i without any clock edge.
- R2: While load_en_i is low, sel_o decodes the address that was on addr_i when load_en_i fell, and later changes on addr_i have no effect on sel_o.
- R3: While cs_i is high, sel_o is 16'h0000, whatever addr_i and load_en_i are.
- R4: While cs_i is low, exactly one bit of sel_o is high. sel_o never has more than one bit high.
- R5: addr_i bit 3 is the most significant bit and bit 0 the least. When the decoded code equals n, sel_o[n] is the bit that is high (sel_o == 1 << n).
- R6: cs_i has no effect on the stored code. An address loaded or held while cs_i is high shows up at sel_o once cs_i goes low.
- R7: With the address fixed, sel_o[addr] equals the inverse of cs_i, and every other bit stays 0 (demultiplexer use).
- R8: While rst_ni is low, the stored code is 0 regardless of load_en_i, so sel_o == 16'h0001 when cs_i is low. After rst_ni rises, the clear persists until the second rising edge of clk_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for reset release, the register variant and checks |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| addr_i | input | 4 | Binary address, bit 3 most significant |
| load_en_i | input | 1 | High: store transparent; low: store holds |
| cs_i | input | 1 | Active-high chip select; high blanks all outputs |
| sel_o | output | 16 | Active-high one-hot decoded outputs |

## Verification
The case hardest to reach from the ports is proving that the held address survives activity it must ignore. The address bus has to change while load-enable is low and while chip-select is high, and the held value can only be seen after select drops again. The directed tasks load a known code, close the store, and then walk the address through unrelated values under both select states. Only then do they release select and compare the decoded bit against the code captured at the falling edge of load-enable. Reset is also asserted while the store is transparent, which shows that the clear wins over load-enable.

// File: rtl/adl_pkg.sv
package adl_pkg;

  typedef enum logic {
    STORE_LATCH = 1'b0,
    STORE_FLOP  = 1'b1
  } store_kind_e;

  localparam int unsigned ADL_ADDR_W_DEF = 4;

endpackage

// File: rtl/adl_rst_sync.sv
module adl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

  // R8: reset output is low while the raw reset is low
  p_rst_follow_r8: assert property (@(posedge clk_i) !rst_ni |-> !rst_sync_no);

endmodule

// File: rtl/adl_addr_store.sv
module adl_addr_store
  import adl_pkg::*;
#(
  parameter int unsigned ADDR_W     = ADL_ADDR_W_DEF,
  parameter store_kind_e STORE_KIND = STORE_LATCH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] code_o
);

  logic [ADDR_W-1:0] held;

  if (STORE_KIND == STORE_LATCH) begin : g_latch
    always_latch begin
      if (!rst_ni) begin
        held <= '0;
      end else if (load_en_i) begin
        held <= addr_i;
      end
    end

    // R1: transparent store follows the bus
    p_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_en_i |-> (code_o == addr_i));
  end else begin : g_flop
    logic [ADDR_W-1:0] held_d;

    always_comb begin
      held_d = held;
      if (load_en_i) begin
        held_d = addr_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        held <= '0;
      end else begin
        held <= held_d;
      end
    end

    // R1: registered store takes the bus one edge later
    p_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_en_i && $past(rst_ni)) |=> (code_o == $past(addr_i)));
  end

  assign code_o = held;

  // R2: closed store keeps its value between samples
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_en_i && !$past(load_en_i) && $past(rst_ni)) |-> $stable(code_o));

  // R8: reset clears the stored code
  p_clear_r8: assert property (@(posedge clk_i)
    !rst_ni |-> (code_o == '0));

endmodule

// File: rtl/adl_onehot_dec.sv
module adl_onehot_dec #(
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned OUT_N = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] code_i,
  output logic [OUT_N-1:0]  hot_o
);

  for (genvar gi = 0; gi < OUT_N; gi++) begin : g_line
    assign hot_o[gi] = (code_i == ADDR_W'(gi));
  end

endmodule

// File: rtl/adl_select_gate.sv
module adl_select_gate #(
  parameter int unsigned OUT_N = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic [OUT_N-1:0] hot_i,
  output logic [OUT_N-1:0] sel_o
);

  for (genvar gi = 0; gi < OUT_N; gi++) begin : g_and
    assign sel_o[gi] = hot_i[gi] & ~cs_i;
  end

  // R3: select high blanks everything
  p_blank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i |-> (sel_o == '0));

  // R4: never more than one output high
  p_onehot0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  // R4: exactly one output high when selected
  p_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |-> ($countones(sel_o) == 1));

endmodule

// File: rtl/latched_addr_decoder.sv
module latched_addr_decoder
  import adl_pkg::*;
#(
  parameter int unsigned ADDR_W     = ADL_ADDR_W_DEF,
  parameter store_kind_e STORE_KIND = STORE_LATCH,
  localparam int unsigned OUT_N     = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              load_en_i,
  input  logic              cs_i,
  output logic [OUT_N-1:0]  sel_o
);

  logic              rst_n_int;
  logic [ADDR_W-1:0] code;
  logic [OUT_N-1:0]  hot;

  adl_rst_sync #(
    .STAGES (2)
  ) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_int)
  );

  adl_addr_store #(
    .ADDR_W     (ADDR_W),
    .STORE_KIND (STORE_KIND)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .load_en_i (load_en_i),
    .addr_i    (addr_i),
    .code_o    (code)
  );

  adl_onehot_dec #(
    .ADDR_W (ADDR_W)
  ) u_dec (
    .code_i (code),
    .hot_o  (hot)
  );

  adl_select_gate #(
    .OUT_N (OUT_N)
  ) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .cs_i   (cs_i),
    .hot_i  (hot),
    .sel_o  (sel_o)
  );

  // R5: the high output sits at the index of the stored code
  p_index_r5: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !cs_i |-> sel_o[code]);

  // R7: chosen output is the inverse of select
  p_demux_r7: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    sel_o[code] == !cs_i);

endmodule

// File: tb/latched_addr_decoder_tb_top.sv
module latched_addr_decoder_tb_top;

  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic [3:0]  addr;
  logic        le;
  logic        cs;
  logic [15:0] sel;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  latched_addr_decoder dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .addr_i    (addr),
    .load_en_i (le),
    .cs_i      (cs),
    .sel_o     (sel)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] expect_of(input logic [3:0] a, input logic c);
    return c ? 16'h0000 : (16'h0001 << a);
  endfunction

  task automatic chk(input string req, input logic [15:0] exp);
    total++;
    if (sel !== exp) begin
      bad++;
      $display("FAIL %s: sel=%h expected=%h", req, sel, exp);
    end
  endtask

  task automatic chk_onehot(input logic c);
    total++;
    if (c ? (sel !== 16'h0) : ($countones(sel) != 1)) begin
      bad++;
      $display("FAIL R4: sel=%h expected one-hot (cs=%0b)", sel, c);
    end
  endtask

  task automatic step(input logic [3:0] a, input logic l, input logic c);
    @(negedge clk);
    addr = a; le = l; cs = c;
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; addr = 4'd5; le = 1'b1; cs = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R8 reset clears store with load_en high", 16'h0001);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R8 clear persists after first edge", 16'h0001);
    repeat (2) @(negedge clk);
    #1;
    chk("R8 normal after release", 16'h0020);
  endtask

  task automatic t_transparent();
    for (int i = 0; i < 16; i++) begin
      step(4'(i), 1'b1, 1'b0);
      chk("R1 R5 transparent decode", 16'h0001 << i);
      chk_onehot(1'b0);
    end
    @(negedge clk); addr = 4'd12; #1;
    chk("R1 follows mid-cycle", 16'h1000);
  endtask

  task automatic t_hold();
    step(4'd9, 1'b1, 1'b0);
    step(4'd9, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) begin
      step(4'(15 - i), 1'b0, 1'b0);
      chk("R2 address ignored while held", 16'h0200);
    end
    step(4'd3, 1'b1, 1'b0);
    chk("R1 reopen loads new address", 16'h0008);
  endtask

  task automatic t_blank();
    step(4'd7, 1'b1, 1'b1);
    chk("R3 blank transparent", 16'h0000);
    chk_onehot(1'b1);
    step(4'd14, 1'b1, 1'b1);
    chk("R3 blank transparent other addr", 16'h0000);
    step(4'd14, 1'b0, 1'b1);
    step(4'd1, 1'b0, 1'b1);
    chk("R3 blank while holding", 16'h0000);
    step(4'd1, 1'b0, 1'b0);
    chk("R2 R6 held code after blank", 16'h4000);
  endtask

  task automatic t_cs_store();
    step(4'd11, 1'b1, 1'b1);
    step(4'd11, 1'b0, 1'b1);
    step(4'd2, 1'b0, 1'b1);
    step(4'd2, 1'b0, 1'b0);
    chk("R6 code loaded under select high", 16'h0800);
  endtask

  task automatic t_demux();
    logic [7:0] data;
    data = 8'b1011_0010;
    step(4'd6, 1'b1, 1'b0);
    step(4'd6, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      step(4'd0, 1'b0, ~data[i]);
      chk("R7 demux data", data[i] ? 16'h0040 : 16'h0000);
    end
    step(4'd4, 1'b1, 1'b0);
    chk("R7 demux reselect", expect_of(4'd4, 1'b0));
  endtask

  task automatic t_reset_mid();
    step(4'd13, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R8 async clear while holding", 16'h0001);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 held code stays zero after release", 16'h0001);
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_transparent();
    t_hold();
    t_blank();
    t_cs_store();
    t_demux();
    t_reset_mid();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule